// File: doc/BRIEF.md
# Indirect Memory Access Window

This block is a small host-facing register window that reaches two kinds of internal resource through address/data register pairs. The first kind is a word-addressed internal SRAM. The second kind is a space of internal peripheral registers. The host sets an address register and then reads or writes the matching data register, and the window turns that data access into one access on the internal port.

For the SRAM, reads and writes each have their own pointer. Every data access through a pointer moves that pointer on by one 32-bit word, so the host can stream a block of memory with repeated data accesses. For the peripherals, each address word holds a 16-bit register offset and a two-bit size field. That address stays fixed across data accesses. Writes drive byte enables that fill the low bytes of the word.

Host requests use a valid/ready handshake, and every accepted request gets exactly one response on a valid/ready response channel. Only one request is in flight at a time. An access-granted input gates all host writes, and reads made while it is low return all-ones.

Top module: `ind_mem_window`

## Requirements
- R1: After reset, `host_req_ready` is high, `host_rsp_valid`, `mem_req` and `prph_req` are low, and all four address registers read back as zero.
- R2: `host_req_sel` selects a window register: 0 memory read pointer, 1 memory write pointer, 2 memory write data, 3 memory read data, 4 peripheral write address, 5 peripheral read address, 6 peripheral write data, 7 peripheral read data. A read of codes 0, 1, 4 or 5 returns the stored word. A read of a write-data register (2, 6) returns zero and starts no internal access. A write to a read-data register (3, 7) has no effect and starts no internal access.
- R3: A granted write to code 2 makes a one-cycle `mem_req` with `mem_we` high in the cycle after acceptance. That access carries the write pointer and the host data. The write pointer then advances by 4.
- R4: A granted read of code 3 makes a one-cycle read on the memory port at the read pointer in the cycle after acceptance. `mem_rdata` is taken one cycle after `mem_req`. The response becomes valid three cycles after acceptance and carries that word. The read pointer then advances by 4.
- R5: The memory read pointer and write pointer are independent. Loading or advancing one leaves the other unchanged.
- R6: A granted write to code 6 makes a one-cycle `prph_req` with `prph_we` high. `prph_addr` is taken from bits 15:0 of the peripheral write address. `prph_be` is built from bits 25:24 of that address, read as a byte count minus one: 0 gives 0001, 1 gives 0011, 2 gives 0111, 3 gives 1111. The peripheral write address does not change.
- R7: A granted read of code 7 reads the peripheral port at the offset and size held in the peripheral read address. It returns `prph_rdata` (taken one cycle after `prph_req`) three cycles after acceptance. The read address does not change.
- R8: A request accepted while `access_ok` is low starts no internal access and changes no register. A write still gets a response of zero, and a read gets a response of all-ones.
- R9: Between acceptance and the consumption of the response, `host_req_ready` is low. While `host_rsp_valid` is high and `host_rsp_ready` is low, the response holds its data. Writes and register readbacks respond in the cycle after acceptance, and write responses carry zero.
- R10: Memory pointers advance modulo 2^32, so a pointer at 0xFFFFFFFC becomes 0 after one data access.
- R11: `mem_req` and `prph_req` are never high together, and each is high for only one cycle per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| access_ok | input | 1 | Internal resources may be accessed; sampled at request acceptance |
| host_req_valid | input | 1 | Host request present |
| host_req_ready | output | 1 | Window can accept a request |
| host_req_write | input | 1 | 1 for a write, 0 for a read |
| host_req_sel | input | 3 | Window register code (see R2) |
| host_req_wdata | input | 32 | Write data |
| host_rsp_valid | output | 1 | Response present |
| host_rsp_ready | input | 1 | Host takes the response |
| host_rsp_rdata | output | 32 | Read data, or zero for writes |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after a read strobe |
| prph_req | output | 1 | Peripheral access strobe |
| prph_we | output | 1 | Peripheral access is a write |
| prph_addr | output | 16 | Peripheral register offset |
| prph_be | output | 4 | Peripheral byte enables, low-aligned |
| prph_wdata | output | 32 | Peripheral write data |
| prph_rdata | input | 32 | Peripheral read data, one cycle after a read strobe |

## Verification
In one cycle, the acceptance of a data access can meet a change of the grant input. The bench drops `access_ok` before a pointer write, a memory-data write and a memory-data read. It then checks that no strobe appears, that the read returns all-ones, and that the pointer read back after the grant returns holds its old value. A second collision is a response held under back-pressure while a new request waits at the input. The bench holds `host_rsp_ready` low for several cycles, checks each cycle that the data stays fixed and that `host_req_ready` stays low, and then confirms that the next access starts only after the response is taken.

// File: rtl/iw_pkg.sv
package iw_pkg;

  localparam int unsigned SEL_W    = 3;
  localparam int unsigned NUM_PTRS = 4;
  localparam int unsigned PTR_MRD  = 0;
  localparam int unsigned PTR_MWR  = 1;
  localparam int unsigned PTR_PWR  = 2;
  localparam int unsigned PTR_PRD  = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_MRPTR = 3'd0,
    SEL_MWPTR = 3'd1,
    SEL_MWDAT = 3'd2,
    SEL_MRDAT = 3'd3,
    SEL_PWADR = 3'd4,
    SEL_PRADR = 3'd5,
    SEL_PWDAT = 3'd6,
    SEL_PRDAT = 3'd7
  } win_sel_e;

  typedef enum logic [2:0] {
    K_IMM,
    K_MEM_WR,
    K_MEM_RD,
    K_PRPH_WR,
    K_PRPH_RD
  } acc_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_CAPT,
    ST_RESP
  } seq_state_e;

endpackage

// File: rtl/iw_ptr_reg.sv
module iw_ptr_reg #(
  parameter int unsigned W      = 32,
  parameter int unsigned STEP   = 4,
  parameter bit          INC_EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         inc,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] q
);

  localparam logic [W-1:0] STEP_V = W'(STEP);

  // load wins over advance; advance wraps modulo 2^W
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (load) begin
      q <= load_val;
    end else if (INC_EN && inc) begin
      q <= q + STEP_V;
    end
  end

endmodule

// File: rtl/iw_size_be.sv
module iw_size_be #(
  parameter int unsigned BE_W = 4,
  parameter int unsigned SZ_W = 2
) (
  input  logic [SZ_W-1:0] size,
  output logic [BE_W-1:0] be
);

  // byte b is enabled when b <= size (size is byte count minus one)
  for (genvar b = 0; b < BE_W; b++) begin : g_be
    localparam logic [SZ_W:0] IDX = (SZ_W+1)'(b);
    assign be[b] = ({1'b0, size} >= IDX);
  end

endmodule

// File: rtl/iw_seq.sv
module iw_seq
  import iw_pkg::*;
#(
  parameter int unsigned AW   = 32,
  parameter int unsigned DW   = 32,
  parameter int unsigned PAW  = 16,
  parameter int unsigned SZ_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  output logic            accept,
  input  acc_kind_e       kind,
  input  logic [DW-1:0]   imm_data,
  input  logic [AW-1:0]   mem_addr_in,
  input  logic [PAW-1:0]  prph_off_in,
  input  logic [SZ_W-1:0] prph_size_in,
  input  logic [DW-1:0]   wdata,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [DW-1:0]   rsp_rdata,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic            prph_req,
  output logic            prph_we,
  output logic [PAW-1:0]  prph_addr,
  output logic [SZ_W-1:0] prph_size,
  output logic [DW-1:0]   prph_wdata,
  input  logic [DW-1:0]   prph_rdata
);

  seq_state_e      st_q;
  logic            tgt_prph_q;
  logic [DW-1:0]   rsp_q;
  logic [DW-1:0]   wdata_q;
  logic            mem_req_q, mem_we_q;
  logic [AW-1:0]   mem_addr_q;
  logic            prph_req_q, prph_we_q;
  logic [PAW-1:0]  prph_addr_q;
  logic [SZ_W-1:0] prph_size_q;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      tgt_prph_q  <= 1'b0;
      rsp_q       <= '0;
      wdata_q     <= '0;
      mem_req_q   <= 1'b0;
      mem_we_q    <= 1'b0;
      mem_addr_q  <= '0;
      prph_req_q  <= 1'b0;
      prph_we_q   <= 1'b0;
      prph_addr_q <= '0;
      prph_size_q <= '0;
    end else begin
      mem_req_q  <= 1'b0;
      prph_req_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (accept) begin
            wdata_q <= wdata;
            case (kind)
              K_MEM_WR: begin
                mem_req_q  <= 1'b1;
                mem_we_q   <= 1'b1;
                mem_addr_q <= mem_addr_in;
                rsp_q      <= '0;
                st_q       <= ST_RESP;
              end
              K_MEM_RD: begin
                mem_req_q  <= 1'b1;
                mem_we_q   <= 1'b0;
                mem_addr_q <= mem_addr_in;
                tgt_prph_q <= 1'b0;
                st_q       <= ST_ISSUE;
              end
              K_PRPH_WR: begin
                prph_req_q  <= 1'b1;
                prph_we_q   <= 1'b1;
                prph_addr_q <= prph_off_in;
                prph_size_q <= prph_size_in;
                rsp_q       <= '0;
                st_q        <= ST_RESP;
              end
              K_PRPH_RD: begin
                prph_req_q  <= 1'b1;
                prph_we_q   <= 1'b0;
                prph_addr_q <= prph_off_in;
                prph_size_q <= prph_size_in;
                tgt_prph_q  <= 1'b1;
                st_q        <= ST_ISSUE;
              end
              default: begin
                rsp_q <= imm_data;
                st_q  <= ST_RESP;
              end
            endcase
          end
        end
        ST_ISSUE: st_q <= ST_CAPT;
        ST_CAPT: begin
          rsp_q <= tgt_prph_q ? prph_rdata : mem_rdata;
          st_q  <= ST_RESP;
        end
        ST_RESP: begin
          if (rsp_ready) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid  = (st_q == ST_RESP);
  assign rsp_rdata  = rsp_q;
  assign mem_req    = mem_req_q;
  assign mem_we     = mem_we_q;
  assign mem_addr   = mem_addr_q;
  assign mem_wdata  = wdata_q;
  assign prph_req   = prph_req_q;
  assign prph_we    = prph_we_q;
  assign prph_addr  = prph_addr_q;
  assign prph_size  = prph_size_q;
  assign prph_wdata = wdata_q;

endmodule

// File: rtl/ind_mem_window.sv
module ind_mem_window
  import iw_pkg::*;
#(
  parameter int unsigned AW      = 32,
  parameter int unsigned DW      = 32,
  parameter int unsigned PAW     = 16,
  parameter int unsigned SZ_W    = 2,
  parameter int unsigned SZ_LSB  = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 access_ok,
  input  logic                 host_req_valid,
  output logic                 host_req_ready,
  input  logic                 host_req_write,
  input  logic [SEL_W-1:0]     host_req_sel,
  input  logic [DW-1:0]        host_req_wdata,
  output logic                 host_rsp_valid,
  input  logic                 host_rsp_ready,
  output logic [DW-1:0]        host_rsp_rdata,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [AW-1:0]        mem_addr,
  output logic [DW-1:0]        mem_wdata,
  input  logic [DW-1:0]        mem_rdata,
  output logic                 prph_req,
  output logic                 prph_we,
  output logic [PAW-1:0]       prph_addr,
  output logic [DW/8-1:0]      prph_be,
  output logic [DW-1:0]        prph_wdata,
  input  logic [DW-1:0]        prph_rdata
);

  localparam int unsigned BE_W = DW / 8;

  win_sel_e              sel;
  acc_kind_e             kind;
  logic [DW-1:0]         imm;
  logic [NUM_PTRS-1:0]   ld, inc;
  logic                  accept;
  logic [AW-1:0]         ptr_q [NUM_PTRS];
  logic [AW-1:0]         mem_addr_in;
  logic [AW-1:0]         prph_word;
  logic [SZ_W-1:0]       prph_size;

  assign sel = win_sel_e'(host_req_sel);

  // request decode, then gating by the grant
  always_comb begin
    kind = K_IMM;
    imm  = '0;
    ld   = '0;
    inc  = '0;
    unique case (sel)
      SEL_MRPTR: if (host_req_write) ld[PTR_MRD] = 1'b1; else imm = DW'(ptr_q[PTR_MRD]);
      SEL_MWPTR: if (host_req_write) ld[PTR_MWR] = 1'b1; else imm = DW'(ptr_q[PTR_MWR]);
      SEL_PWADR: if (host_req_write) ld[PTR_PWR] = 1'b1; else imm = DW'(ptr_q[PTR_PWR]);
      SEL_PRADR: if (host_req_write) ld[PTR_PRD] = 1'b1; else imm = DW'(ptr_q[PTR_PRD]);
      SEL_MWDAT: if (host_req_write) begin kind = K_MEM_WR; inc[PTR_MWR] = 1'b1; end
      SEL_MRDAT: if (!host_req_write) begin kind = K_MEM_RD; inc[PTR_MRD] = 1'b1; end
      SEL_PWDAT: if (host_req_write) kind = K_PRPH_WR;
      SEL_PRDAT: if (!host_req_write) kind = K_PRPH_RD;
      default: kind = K_IMM;
    endcase
    if (!access_ok) begin
      kind = K_IMM;
      imm  = host_req_write ? '0 : '1;
      ld   = '0;
      inc  = '0;
    end
  end

  for (genvar i = 0; i < NUM_PTRS; i++) begin : g_ptr
    iw_ptr_reg #(
      .W      (AW),
      .STEP   (BE_W),
      .INC_EN (i < 2)
    ) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld[i] && accept),
      .inc      (inc[i] && accept),
      .load_val (host_req_wdata[AW-1:0]),
      .q        (ptr_q[i])
    );
  end

  assign mem_addr_in = (sel == SEL_MRDAT) ? ptr_q[PTR_MRD] : ptr_q[PTR_MWR];
  assign prph_word   = (sel == SEL_PRDAT) ? ptr_q[PTR_PRD] : ptr_q[PTR_PWR];

  iw_seq #(
    .AW   (AW),
    .DW   (DW),
    .PAW  (PAW),
    .SZ_W (SZ_W)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (host_req_valid),
    .req_ready    (host_req_ready),
    .accept       (accept),
    .kind         (kind),
    .imm_data     (imm),
    .mem_addr_in  (mem_addr_in),
    .prph_off_in  (prph_word[PAW-1:0]),
    .prph_size_in (prph_word[SZ_LSB +: SZ_W]),
    .wdata        (host_req_wdata),
    .rsp_valid    (host_rsp_valid),
    .rsp_ready    (host_rsp_ready),
    .rsp_rdata    (host_rsp_rdata),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_rdata    (mem_rdata),
    .prph_req     (prph_req),
    .prph_we      (prph_we),
    .prph_addr    (prph_addr),
    .prph_size    (prph_size),
    .prph_wdata   (prph_wdata),
    .prph_rdata   (prph_rdata)
  );

  iw_size_be #(
    .BE_W (BE_W),
    .SZ_W (SZ_W)
  ) u_be (
    .size (prph_size),
    .be   (prph_be)
  );

endmodule

// File: rtl/iw_window_chk.sv
module iw_window_chk #(
  parameter int unsigned DW   = 32,
  parameter int unsigned BE_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            access_ok,
  input logic            host_req_valid,
  input logic            host_req_ready,
  input logic            host_rsp_valid,
  input logic            host_rsp_ready,
  input logic [DW-1:0]   host_rsp_rdata,
  input logic            mem_req,
  input logic            mem_we,
  input logic            prph_req,
  input logic [BE_W-1:0] prph_be
);

  logic acc;
  assign acc = host_req_valid && host_req_ready;

  a_r3_strobe_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || prph_req) |-> $past(acc));

  a_r4_no_rsp_in_return_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> !host_rsp_valid);

  a_r6_be_low_contig: assert property (@(posedge clk) disable iff (!rst_n)
    prph_req |-> (prph_be[0] && ((prph_be & (prph_be + 1'b1)) == '0)));

  a_r8_no_access_ungranted: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !access_ok) |=> (!mem_req && !prph_req));

  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !host_req_ready);

  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rsp_valid && !host_rsp_ready) |=> (host_rsp_valid && $stable(host_rsp_rdata)));

  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && prph_req));

  a_r11_mem_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  a_r11_prph_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    prph_req |=> !prph_req);

endmodule

bind ind_mem_window iw_window_chk #(
  .DW   (DW),
  .BE_W (DW/8)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .access_ok      (access_ok),
  .host_req_valid (host_req_valid),
  .host_req_ready (host_req_ready),
  .host_rsp_valid (host_rsp_valid),
  .host_rsp_ready (host_rsp_ready),
  .host_rsp_rdata (host_rsp_rdata),
  .mem_req        (mem_req),
  .mem_we         (mem_we),
  .prph_req       (prph_req),
  .prph_be        (prph_be)
);

// File: tb/ind_mem_window_tb_top.sv
module ind_mem_window_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        access_ok = 1'b1;
  logic        host_req_valid = 1'b0;
  logic        host_req_ready;
  logic        host_req_write = 1'b0;
  logic [2:0]  host_req_sel = 3'd0;
  logic [31:0] host_req_wdata = '0;
  logic        host_rsp_valid;
  logic        host_rsp_ready = 1'b0;
  logic [31:0] host_rsp_rdata;
  logic        mem_req, mem_we, prph_req, prph_we;
  logic [31:0] mem_addr, mem_wdata, prph_wdata;
  logic [31:0] mem_rdata = '0;
  logic [31:0] prph_rdata = '0;
  logic [15:0] prph_addr;
  logic [3:0]  prph_be;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ind_mem_window dut_i (
    .clk(clk), .rst_n(rst_n), .access_ok(access_ok),
    .host_req_valid(host_req_valid), .host_req_ready(host_req_ready),
    .host_req_write(host_req_write), .host_req_sel(host_req_sel),
    .host_req_wdata(host_req_wdata), .host_rsp_valid(host_rsp_valid),
    .host_rsp_ready(host_rsp_ready), .host_rsp_rdata(host_rsp_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .prph_req(prph_req), .prph_we(prph_we), .prph_addr(prph_addr),
    .prph_be(prph_be), .prph_wdata(prph_wdata), .prph_rdata(prph_rdata)
  );

  // memory and peripheral models
  logic [31:0] marr [16];
  logic [31:0] parr [8];
  int mwr_cnt = 0, mrd_cnt = 0, pacc_cnt = 0, both_cnt = 0;
  logic [31:0] last_maddr = '0;
  logic [15:0] last_paddr = '0;
  logic [3:0]  last_pbe = '0;

  initial begin
    for (int i = 0; i < 16; i++) marr[i] = 32'hA500_0000 | i;
    for (int i = 0; i < 8; i++) parr[i] = '0;
  end

  always @(posedge clk) begin
    if (mem_req && prph_req) both_cnt++;
    if (mem_req) begin
      last_maddr = mem_addr;
      if (mem_we) begin marr[mem_addr[5:2]] = mem_wdata; mwr_cnt++; end
      else begin mem_rdata <= marr[mem_addr[5:2]]; mrd_cnt++; end
    end
    if (prph_req) begin
      pacc_cnt++;
      last_paddr = prph_addr;
      last_pbe = prph_be;
      if (prph_we) begin
        for (int b = 0; b < 4; b++)
          if (prph_be[b]) parr[prph_addr[4:2]][8*b +: 8] = prph_wdata[8*b +: 8];
      end else begin
        prph_rdata <= parr[prph_addr[4:2]];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [2:0] sel, input logic [31:0] wd,
                        input int hold, output logic [31:0] rd, output int lat);
    @(negedge clk);
    host_req_valid = 1'b1; host_req_write = wr; host_req_sel = sel; host_req_wdata = wd;
    while (!host_req_ready) @(negedge clk);
    @(negedge clk);
    host_req_valid = 1'b0;
    lat = 1;
    while (!host_rsp_valid) begin @(negedge clk); lat++; end
    rd = host_rsp_rdata;
    for (int k = 0; k < hold; k++) begin
      chk(!host_req_ready, "R9 ready low while response pending", 32'(host_req_ready), 32'd0);
      @(negedge clk);
      chk(host_rsp_valid && host_rsp_rdata === rd, "R9 response held", host_rsp_rdata, rd);
    end
    host_rsp_ready = 1'b1;
    @(negedge clk);
    host_rsp_ready = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] rd; int lat;
    chk(host_req_ready === 1'b1, "R1 ready", 32'(host_req_ready), 32'd1);
    chk(!host_rsp_valid && !mem_req && !prph_req, "R1 outputs idle",
        {29'd0, host_rsp_valid, mem_req, prph_req}, 32'd0);
    for (int s = 0; s < 8; s++) begin
      if (s == 0 || s == 1 || s == 4 || s == 5) begin
        access(1'b0, 3'(s), '0, 0, rd, lat);
        chk(rd === 32'd0, "R1 address register zero after reset", rd, 32'd0);
      end
    end
  endtask

  task automatic t_mem_write();
    logic [31:0] rd; int lat; int c0;
    access(1'b1, 3'd1, 32'h0000_0020, 0, rd, lat);
    c0 = mwr_cnt;
    for (int i = 0; i < 3; i++) begin
      access(1'b1, 3'd2, 32'h1111_0000 + i, 0, rd, lat);
      chk(lat == 1, "R9 write response latency", 32'(lat), 32'd1);
      chk(rd === 32'd0, "R9 write response zero", rd, 32'd0);
    end
    chk(mwr_cnt == c0 + 3, "R3 memory write count", 32'(mwr_cnt - c0), 32'd3);
    chk(marr[8] === 32'h1111_0000, "R3 word at 0x20", marr[8], 32'h1111_0000);
    chk(marr[10] === 32'h1111_0002, "R3 word at 0x28", marr[10], 32'h1111_0002);
    chk(last_maddr === 32'h28, "R3 last write address", last_maddr, 32'h28);
    access(1'b0, 3'd1, '0, 0, rd, lat);
    chk(rd === 32'h2C, "R3 write pointer advanced", rd, 32'h2C);
    access(1'b0, 3'd0, '0, 0, rd, lat);
    chk(rd === 32'h0, "R5 read pointer untouched by writes", rd, 32'h0);
  endtask

  task automatic t_mem_read();
    logic [31:0] rd; int lat;
    logic [31:0] exp [3];
    exp[0] = 32'hA500_0007; exp[1] = 32'h1111_0000; exp[2] = 32'h1111_0001;
    access(1'b1, 3'd0, 32'h0000_001C, 0, rd, lat);
    for (int i = 0; i < 3; i++) begin
      access(1'b0, 3'd3, '0, 0, rd, lat);
      chk(rd === exp[i], "R4 streamed read data", rd, exp[i]);
      chk(lat == 3, "R4 read response latency", 32'(lat), 32'd3);
    end
    access(1'b0, 3'd0, '0, 0, rd, lat);
    chk(rd === 32'h28, "R4 read pointer advanced", rd, 32'h28);
    access(1'b0, 3'd1, '0, 0, rd, lat);
    chk(rd === 32'h2C, "R5 write pointer untouched by reads", rd, 32'h2C);
  endtask

  task automatic t_prph();
    logic [31:0] rd; int lat; logic [31:0] awd, m; logic [3:0] ebe;
    for (int sz = 0; sz < 4; sz++) begin
      awd = (32'(sz) << 24) | (32'h100 + 32'(4 * sz));
      ebe = 4'((5'd1 << (sz + 1)) - 5'd1);
      access(1'b1, 3'd4, awd, 0, rd, lat);
      access(1'b1, 3'd6, 32'hCAFE_BA90 | 32'(sz), 0, rd, lat);
      chk(last_pbe === ebe, "R6 byte enables from size", 32'(last_pbe), 32'(ebe));
      chk(last_paddr === awd[15:0], "R6 peripheral offset", 32'(last_paddr), 32'(awd[15:0]));
      access(1'b0, 3'd4, '0, 0, rd, lat);
      chk(rd === awd, "R6 write address not advanced", rd, awd);
      m = (sz == 3) ? 32'hFFFF_FFFF : ((32'd1 << (8 * (sz + 1))) - 32'd1);
      access(1'b1, 3'd5, 32'h0300_0000 | (32'h100 + 32'(4 * sz)), 0, rd, lat);
      for (int r = 0; r < 2; r++) begin
        access(1'b0, 3'd7, '0, 0, rd, lat);
        chk(rd === ((32'hCAFE_BA90 | 32'(sz)) & m), "R7 peripheral read data",
            rd, (32'hCAFE_BA90 | 32'(sz)) & m);
        chk(lat == 3, "R7 read latency", 32'(lat), 32'd3);
      end
      access(1'b0, 3'd5, '0, 0, rd, lat);
      chk(rd === (32'h0300_0000 | (32'h100 + 32'(4 * sz))), "R7 read address not advanced",
          rd, 32'h0300_0000 | (32'h100 + 32'(4 * sz)));
    end
  endtask

  task automatic t_misdir();
    logic [31:0] rd; int lat; int mw, mr, pa;
    mw = mwr_cnt; mr = mrd_cnt; pa = pacc_cnt;
    access(1'b1, 3'd3, 32'hDEAD_0001, 0, rd, lat);
    access(1'b1, 3'd7, 32'hDEAD_0002, 0, rd, lat);
    access(1'b0, 3'd2, '0, 0, rd, lat);
    chk(rd === 32'd0, "R2 write-data register reads zero", rd, 32'd0);
    access(1'b0, 3'd6, '0, 0, rd, lat);
    chk(rd === 32'd0, "R2 peripheral write-data reads zero", rd, 32'd0);
    chk(mwr_cnt == mw && mrd_cnt == mr && pacc_cnt == pa, "R2 no internal access",
        32'(mwr_cnt + mrd_cnt + pacc_cnt), 32'(mw + mr + pa));
    access(1'b0, 3'd0, '0, 0, rd, lat);
    chk(rd === 32'h28, "R2 read pointer unchanged", rd, 32'h28);
  endtask

  task automatic t_grant();
    logic [31:0] rd; int lat; int mw, mr, pa;
    mw = mwr_cnt; mr = mrd_cnt; pa = pacc_cnt;
    @(negedge clk); access_ok = 1'b0;
    access(1'b1, 3'd1, 32'h0000_0040, 0, rd, lat);
    chk(rd === 32'd0, "R8 gated write response zero", rd, 32'd0);
    access(1'b1, 3'd2, 32'h5555_5555, 0, rd, lat);
    access(1'b0, 3'd3, '0, 0, rd, lat);
    chk(rd === 32'hFFFF_FFFF, "R8 gated read returns ones", rd, 32'hFFFF_FFFF);
    access(1'b0, 3'd0, '0, 0, rd, lat);
    chk(rd === 32'hFFFF_FFFF, "R8 gated pointer read returns ones", rd, 32'hFFFF_FFFF);
    chk(mwr_cnt == mw && mrd_cnt == mr && pacc_cnt == pa, "R8 no internal access",
        32'(mwr_cnt + mrd_cnt + pacc_cnt), 32'(mw + mr + pa));
    @(negedge clk); access_ok = 1'b1;
    access(1'b0, 3'd1, '0, 0, rd, lat);
    chk(rd === 32'h2C, "R8 write pointer unchanged", rd, 32'h2C);
    access(1'b0, 3'd0, '0, 0, rd, lat);
    chk(rd === 32'h28, "R8 read pointer unchanged", rd, 32'h28);
  endtask

  task automatic t_wrap();
    logic [31:0] rd; int lat;
    access(1'b1, 3'd1, 32'hFFFF_FFFC, 0, rd, lat);
    access(1'b1, 3'd2, 32'h7777_AAAA, 0, rd, lat);
    chk(marr[15] === 32'h7777_AAAA, "R10 write at top word", marr[15], 32'h7777_AAAA);
    access(1'b0, 3'd1, '0, 0, rd, lat);
    chk(rd === 32'd0, "R10 pointer wraps to zero", rd, 32'd0);
  endtask

  task automatic t_backpressure();
    logic [31:0] rd; int lat;
    access(1'b1, 3'd0, 32'h0000_0020, 0, rd, lat);
    access(1'b0, 3'd3, '0, 4, rd, lat);
    chk(rd === 32'h1111_0000, "R9 held read data", rd, 32'h1111_0000);
    access(1'b0, 3'd3, '0, 0, rd, lat);
    chk(rd === 32'h1111_0001, "R9 next access after release", rd, 32'h1111_0001);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mem_write();
    t_mem_read();
    t_prph();
    t_misdir();
    t_grant();
    t_wrap();
    t_backpressure();
    chk(both_cnt == 0, "R11 strobes never together", 32'(both_cnt), 32'd0);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule